// File: doc/BRIEF.md
# Multi-Cycle Right Shifter with Sticky Status

This block executes two right-shift operations one bit position per clock: an arithmetic shift of a 32-bit word and a logical shift of an 8-bit byte. A start pulse captures an opcode, the operand, an incoming carry, an incoming overflow-trap bit and a count byte. The count byte can act in two ways. A small value is the shift count itself. A larger value is the address of a register, and that register holds the count.

The register file is outside the block. It is reached through a combinational read port: the block drives an address, and the file returns the data in the same cycle. The block raises busy while it works. At the end it pulses done once, together with the shifted result and the zero, negative, carry, overflow, sticky and overflow-trap flags. These outputs hold their values until the next accepted start.

Top module: `rshift_unit`

## Requirements
- R1: Opcode 0x0E selects the arithmetic 32-bit shift and opcode 0x18 selects the logical byte shift. A start with any other opcode is ignored: busy stays low, done does not pulse and the outputs keep their values.
- R2: A count byte below 0x10 is an immediate shift count of 0 to 15.
- R3: A count byte of 0x10 or above appears on regAddr, and the shift count is the low five bits of regData, so register values above 31 wrap modulo 32.
- R4: In the arithmetic form every vacated high bit takes the operand's original sign. A shift of 31 places leaves all zeroes or all ones.
- R5: In the logical byte form the byte operand (operand[7:0]) is shifted with zero fill, and result[31:8] is zero.
- R6: flagC holds the last bit shifted out. With a count of zero no shift happens, the operand is returned unchanged and flagC equals cIn.
- R7: flagSticky is cleared at start. It is set when a 1 is in carry from an earlier iteration and another iteration follows.
- R8: flagZ is set when the result is zero. flagN is result[31] for the arithmetic form and 0 for the byte form.
- R9: flagV is 0 at done, and flagVt equals the vtIn value captured at start.
- R10: busy rises in the cycle after an accepted start and stays high up to and including the done cycle. Done is a one-cycle pulse that comes n+1 clock edges after the start edge, where n is the shift count.
- R11: A start while busy is ignored. The running operation finishes with its own result and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| opcode | input | 8 | Operation select (0x0E or 0x18) |
| operand | input | 32 | Destination operand; byte form uses bits 7:0 |
| countByte | input | 8 | Immediate count or count register address |
| cIn | input | 1 | Carry before the operation |
| vtIn | input | 1 | Overflow-trap flag before the operation |
| regAddr | output | 8 | Register read address |
| regData | input | 8 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Shifted value |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag (always 0) |
| flagSticky | output | 1 | Sticky flag |
| flagVt | output | 1 | Overflow-trap flag, passed through |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit byte and address, an immediate limit of 16 and a five-bit register count. With these values every count from 0 to 31 can be reached, so tests cover the count of zero, the largest immediate of 15 and a full 31-place arithmetic shift through a register. Register values above 31 can also be applied to exercise the modulo-32 wrap. Because the byte is only eight bits wide, a 15-place byte shift runs past the width of the operand, which drives the carry to zero after the data has run out.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

  localparam logic [7:0] OP_SRA_WORD = 8'h0E;
  localparam logic [7:0] OP_SRL_BYTE = 8'h18;

  typedef struct packed {
    logic capture;
    logic loadCount;
    logic shiftStep;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_FIN
  } ctrlState_t;

endpackage

// File: rtl/rshift_ctrl.sv
module rshift_ctrl
  import rshift_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [7:0]   opcode,
  input  logic         countIsZero,
  input  logic         remIsOne,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  ctrlState_t state, stateNext;
  logic opLegal;

  assign opLegal = (opcode == OP_SRA_WORD) || (opcode == OP_SRL_BYTE);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start && opLegal) begin
          strobes.capture = 1'b1;
          stateNext       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strobes.loadCount = 1'b1;
        stateNext         = countIsZero ? ST_FIN : ST_SHIFT;
      end
      ST_SHIFT: begin
        strobes.shiftStep = 1'b1;
        if (remIsOne) stateNext = ST_FIN;
      end
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/rshift_dpath.sv
module rshift_dpath
  import rshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int IMM_LIMIT = 16,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] countByte,
  input  logic              cIn,
  input  logic              vtIn,
  output logic [ADDR_W-1:0] regAddr,
  input  logic [ADDR_W-1:0] regData,
  output logic              countIsZero,
  output logic              remIsOne,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagC,
  output logic              flagV,
  output logic              flagSticky,
  output logic              flagVt
);

  localparam logic [ADDR_W-1:0] CNT_MASK = ADDR_W'((1 << CNT_W) - 1);
  localparam logic [ADDR_W-1:0] IMM_MAX  = ADDR_W'(IMM_LIMIT);

  logic [DATA_W-1:0] acc;
  logic [ADDR_W-1:0] cntByte;
  logic [ADDR_W-1:0] rem;
  logic [ADDR_W-1:0] cntSel;
  logic              byteMode;
  logic              carry;
  logic              sticky;
  logic              shifted;
  logic              vt;
  logic              fillBit;

  assign regAddr     = cntByte;
  assign cntSel      = (cntByte < IMM_MAX) ? cntByte : (regData & CNT_MASK);
  assign countIsZero = (cntSel == '0);
  assign remIsOne    = (rem == ADDR_W'(1));
  assign fillBit     = byteMode ? 1'b0 : acc[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      cntByte  <= '0;
      rem      <= '0;
      byteMode <= 1'b0;
      carry    <= 1'b0;
      sticky   <= 1'b0;
      shifted  <= 1'b0;
      vt       <= 1'b0;
    end else if (strobes.capture) begin
      byteMode <= (opcode == OP_SRL_BYTE);
      acc      <= (opcode == OP_SRL_BYTE) ? DATA_W'(operand[BYTE_W-1:0]) : operand;
      cntByte  <= countByte;
      carry    <= cIn;
      sticky   <= 1'b0;
      shifted  <= 1'b0;
      vt       <= vtIn;
    end else if (strobes.loadCount) begin
      rem <= cntSel;
    end else if (strobes.shiftStep) begin
      sticky  <= sticky | (shifted & carry);
      carry   <= acc[0];
      acc     <= {fillBit, acc[DATA_W-1:1]};
      rem     <= rem - ADDR_W'(1);
      shifted <= 1'b1;
    end
  end

  assign result     = acc;
  assign flagZ      = (acc == '0);
  assign flagN      = ~byteMode & acc[DATA_W-1];
  assign flagC      = carry;
  assign flagV      = 1'b0;
  assign flagSticky = sticky;
  assign flagVt     = vt;

endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
  import rshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int IMM_LIMIT = 16,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] countByte,
  input  logic              cIn,
  input  logic              vtIn,
  output logic [ADDR_W-1:0] regAddr,
  input  logic [ADDR_W-1:0] regData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagC,
  output logic              flagV,
  output logic              flagSticky,
  output logic              flagVt
);

  ctrlStrobes_t strobes;
  logic countIsZero;
  logic remIsOne;

  rshift_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .opcode      (opcode),
    .countIsZero (countIsZero),
    .remIsOne    (remIsOne),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done)
  );

  rshift_dpath #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .IMM_LIMIT (IMM_LIMIT),
    .CNT_W     (CNT_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .opcode      (opcode),
    .operand     (operand),
    .countByte   (countByte),
    .cIn         (cIn),
    .vtIn        (vtIn),
    .regAddr     (regAddr),
    .regData     (regData),
    .countIsZero (countIsZero),
    .remIsOne    (remIsOne),
    .result      (result),
    .flagZ       (flagZ),
    .flagN       (flagN),
    .flagC       (flagC),
    .flagV       (flagV),
    .flagSticky  (flagSticky),
    .flagVt      (flagVt)
  );

endmodule

// File: rtl/rshift_unit_chk.sv
module rshift_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [7:0] opcode,
  input logic       busy,
  input logic       done,
  input logic       flagV
);

  logic legalOp;
  assign legalOp = (opcode == 8'h0E) || (opcode == 8'h18);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && legalOp) |=> (busy && !done));

  a_r1_illegal_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !legalOp) |=> !busy);

  a_r11_busy_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !flagV);

endmodule

bind rshift_unit rshift_unit_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opcode (opcode),
  .busy   (busy),
  .done   (done),
  .flagV  (flagV)
);

// File: tb/rshift_unit_tb.sv
module rshift_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] operand = '0;
  logic [7:0]  countByte = '0;
  logic        cIn = 1'b0;
  logic        vtIn = 1'b0;
  logic [7:0]  regAddr;
  logic [7:0]  regData;
  logic        busy, done;
  logic [31:0] result;
  logic        flagZ, flagN, flagC, flagV, flagSticky, flagVt;

  logic [7:0]  fileAddr = 8'h40;
  logic [7:0]  fileVal  = 8'h00;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign regData = (regAddr == fileAddr) ? fileVal : 8'hA5;

  rshift_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .countByte(countByte), .cIn(cIn), .vtIn(vtIn), .regAddr(regAddr),
    .regData(regData), .busy(busy), .done(done), .result(result),
    .flagZ(flagZ), .flagN(flagN), .flagC(flagC), .flagV(flagV),
    .flagSticky(flagSticky), .flagVt(flagVt)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Full operation with every output compared against an independent model
  task automatic runOp(input string req, input logic [7:0] op, input logic [31:0] val,
                       input logic [7:0] cb, input logic [7:0] rv,
                       input logic ci, input logic vi);
    int n;
    int cyc;
    logic [31:0] v;
    logic c, st, isByte;
    isByte = (op == 8'h18);
    n = (cb < 8'h10) ? int'(cb) : int'(rv[4:0]);
    v = isByte ? {24'h0, val[7:0]} : val;
    c = ci;
    st = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && c) st = 1'b1;
      c = v[0];
      v = isByte ? (v >> 1) : {v[31], v[31:1]};
    end
    @(negedge clk);
    opcode = op; operand = val; countByte = cb; cIn = ci; vtIn = vi;
    fileAddr = cb; fileVal = rv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(req, "busy after start (R10)", {31'h0, busy}, 32'h1);
    cyc = 1;
    while (!done && cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      if (!done) cyc++;
    end
    check(req, "latency R10", cyc, n + 1);
    check(req, "result", result, v);
    check(req, "flagC R6", {31'h0, flagC}, {31'h0, c});
    check(req, "flagSticky R7", {31'h0, flagSticky}, {31'h0, st});
    check(req, "flagZ R8", {31'h0, flagZ}, {31'h0, v == 32'h0});
    check(req, "flagN R8", {31'h0, flagN}, {31'h0, isByte ? 1'b0 : v[31]});
    check(req, "flagV R9", {31'h0, flagV}, 32'h0);
    check(req, "flagVt R9", {31'h0, flagVt}, {31'h0, vi});
    @(negedge clk);
    check(req, "done single cycle R10", {30'h0, done, busy}, 32'h0);
  endtask

  task automatic testReset();
    check("R10", "reset busy/done", {30'h0, busy, done}, 32'h0);
    check("R8", "reset result", result, 32'h0);
  endtask

  task automatic testIllegal();
    logic [31:0] held;
    held = result;
    @(negedge clk);
    opcode = 8'h20; operand = 32'hDEADBEEF; countByte = 8'h03; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R1", "illegal opcode busy/done", {30'h0, busy, done}, 32'h0);
      @(negedge clk);
    end
    check("R1", "illegal opcode result unchanged", result, held);
  endtask

  task automatic testStartWhileBusy();
    int cyc;
    @(negedge clk);
    opcode = 8'h0E; operand = 32'hF0000000; countByte = 8'h0A; cIn = 1'b0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (3) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
    opcode = 8'h18; operand = 32'h000000FF; countByte = 8'h01; start = 1'b1;
    @(posedge clk); @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 100) begin
      @(posedge clk); @(negedge clk);
      if (!done) cyc++;
    end
    check("R11", "latency kept", cyc, 11);
    check("R11", "result of first operation", result, 32'hFFFC0000);
    @(negedge clk);
    check("R11", "no second operation", {30'h0, busy, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runOp("R4 R7", 8'h0E, 32'h80000001, 8'h04, 8'h00, 1'b0, 1'b0);
    runOp("R5 R7", 8'h18, 32'hFFFFFF03, 8'h02, 8'h00, 1'b0, 1'b0);
    runOp("R5 R6", 8'h18, 32'h00000002, 8'h02, 8'h00, 1'b0, 1'b0);
    runOp("R6 R8", 8'h0E, 32'h80000000, 8'h00, 8'h00, 1'b1, 1'b0);
    runOp("R2", 8'h0E, 32'h7FFF1234, 8'h0F, 8'h00, 1'b0, 1'b0);
    runOp("R3", 8'h0E, 32'h12345678, 8'h40, 8'h25, 1'b0, 1'b0);
    runOp("R3", 8'h18, 32'h000000B6, 8'h10, 8'h03, 1'b1, 1'b0);
    runOp("R4", 8'h0E, 32'h80000000, 8'h77, 8'h1F, 1'b0, 1'b0);
    runOp("R4", 8'h0E, 32'h7FFFFFFF, 8'h77, 8'h1F, 1'b0, 1'b0);
    runOp("R5", 8'h18, 32'h000000FF, 8'h0F, 8'h00, 1'b0, 1'b0);
    runOp("R9", 8'h0E, 32'h00000010, 8'h01, 8'h00, 1'b0, 1'b1);
    runOp("R3", 8'h0E, 32'hC0000000, 8'hF0, 8'hE0, 1'b1, 1'b1);
    testIllegal();
    testStartWhileBusy();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule